// File: doc/BRIEF.md
# Symmetric Resource-Shared Polyphase Subfilter

This block is one unit of a sixteen-unit polyphase filter bank. A prototype low-pass filter of 128 taps is split into 32 branches of four taps each. Branch k takes taps h(k), h(k+32), h(k+64) and h(k+96). The prototype is symmetric, so branch 31-k needs the same four values in the opposite order. This unit therefore serves a branch pair with one set of four coefficient multipliers. The upstream commutator tags each sample with a phase flag. Even-phase samples are filtered with the coefficients in load order. Odd-phase samples are filtered with the same coefficients reversed, which realises the mirror branch.

Each phase has its own transpose-form register chain. The phase flag is the enable of that chain. The same flag steers the shared multiplier and rounding path and picks the output register to update. The unit gives one result per phase, so it also decimates the incoming stream by two. Accumulation keeps full precision. Each result is rounded back to the data width and saturated.

Top module: `sym_poly_subfilter`

## Requirements
- R1: During and after reset, both results are 0, both valid pulses are low, all four coefficients are 0 and both chains are empty.
- R2: One cycle after a sample is accepted with phase 0 (valid high, phase low), the even result equals round(sum over t of c[t]·e[n-t]). Here e[n] is the newest even-phase sample, e[n-1] the one before it, and so on.
- R3: One cycle after a sample is accepted with phase 1, the odd result equals round(sum over t of c[3-t]·o[n-t]). Here o[n] is the newest odd-phase sample, so the coefficient order is reversed.
- R4: An accepted sample of one phase changes neither the result register nor the chain history of the other phase.
- R5: The even valid pulse is high for exactly the cycle after an accepted phase-0 sample, and the odd valid pulse likewise after an accepted phase-1 sample. The two pulses are never high together.
- R6: While sample_valid_i is low, both results hold, no valid pulse appears and the chain histories are unchanged.
- R7: Rounding is round-half-up at the binary point COEF_W-1: result = floor((sum + 2^(COEF_W-2)) / 2^(COEF_W-1)).
- R8: A rounded value above 2^(DATA_W-1)-1 gives that maximum. A value below -2^(DATA_W-1) gives that minimum.
- R9: A write with coef_we_i high stores coef_data_i into c[coef_addr_i]. Index 0 is the coefficient applied to the newest even sample. The write takes effect for products of samples accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | DATA_W | Signed input sample |
| sample_valid_i | input | 1 | Sample is accepted at this edge |
| phase_i | input | 1 | 0 = even phase, 1 = odd phase |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | $clog2(TAPS) | Coefficient index |
| coef_data_i | input | COEF_W | Signed coefficient value |
| even_o | output | DATA_W | Even-phase result |
| even_valid_o | output | 1 | Even result updated last edge |
| odd_o | output | DATA_W | Odd-phase result |
| odd_valid_o | output | 1 | Odd result updated last edge |

## Verification
The bench keeps the default build: 13-bit data, 13-bit coefficients and four taps, so the binary point sits at bit 12. These widths let a lone coefficient of 1 against samples of ±2048 and 2047 land exactly on and beside a rounding tie. Full-scale samples with all coefficients at +4095 or -4096 push the 28-bit sum past both 13-bit limits. With four taps, an impulse walks the whole chain in four samples. The bench can then compare the tap order of the two phases directly.

// File: rtl/sym_poly_pkg.sv
package sym_poly_pkg;
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;
endpackage

// File: rtl/sym_coef_bank.sv
module sym_coef_bank #(
  parameter int TAPS   = 4,
  parameter int COEF_W = 13,
  localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic signed [COEF_W-1:0] data_i,
  input  logic                     odd_sel_i,
  output logic signed [COEF_W-1:0] coef_o [TAPS]
);
  logic signed [COEF_W-1:0] coef_q [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                coef_q[t] <= '0;
      else if (we_i && (32'(addr_i) == t))        coef_q[t] <= data_i;
    end
    // mirror branch applies the set in reversed tap order
    assign coef_o[t] = odd_sel_i ? coef_q[TAPS-1-t] : coef_q[t];
  end
endmodule

// File: rtl/sym_shared_mult.sv
module sym_shared_mult #(
  parameter int TAPS   = 4,
  parameter int DATA_W = 13,
  parameter int COEF_W = 13,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0] coef_i [TAPS],
  output logic signed [PROD_W-1:0] prod_o [TAPS]
);
  for (genvar t = 0; t < TAPS; t++) begin : g_mul
    assign prod_o[t] = PROD_W'(sample_i) * PROD_W'(coef_i[t]);
  end
endmodule

// File: rtl/sym_tap_chain.sv
module sym_tap_chain #(
  parameter int TAPS   = 4,
  parameter int PROD_W = 26,
  parameter int ACC_W  = 28
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [PROD_W-1:0] prod_i [TAPS],
  output logic signed [ACC_W-1:0]  sum_o
);
  logic signed [ACC_W-1:0] acc_q [TAPS-1];

  for (genvar t = 0; t < TAPS - 1; t++) begin : g_stage
    logic signed [ACC_W-1:0] nxt;
    if (t == TAPS - 2) begin : g_last
      assign nxt = ACC_W'(prod_i[t+1]);
    end else begin : g_mid
      assign nxt = ACC_W'(prod_i[t+1]) + acc_q[t+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q[t] <= '0;
      else if (en_i)  acc_q[t] <= nxt;
    end
  end

  assign sum_o = ACC_W'(prod_i[0]) + acc_q[0];
endmodule

// File: rtl/sym_round_sat.sv
module sym_round_sat #(
  parameter int ACC_W  = 28,
  parameter int DATA_W = 13,
  parameter int SHIFT  = 12
) (
  input  logic signed [ACC_W-1:0]  sum_i,
  output logic signed [DATA_W-1:0] res_o
);
  localparam int EW = ACC_W + 1;
  localparam logic signed [EW-1:0] MAX_V = EW'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [EW-1:0] MIN_V = -EW'(64'sd1 <<< (DATA_W-1));

  logic signed [EW-1:0] shifted;

  if (SHIFT > 0) begin : g_rnd
    localparam logic signed [EW-1:0] HALF = EW'(64'sd1 <<< (SHIFT-1));
    logic signed [EW-1:0] biased;
    assign biased  = EW'(sum_i) + HALF;
    assign shifted = biased >>> SHIFT;
  end else begin : g_nornd
    assign shifted = EW'(sum_i);
  end

  always_comb begin
    if (shifted > MAX_V)      res_o = MAX_V[DATA_W-1:0];
    else if (shifted < MIN_V) res_o = MIN_V[DATA_W-1:0];
    else                      res_o = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/sym_poly_subfilter.sv
module sym_poly_subfilter
  import sym_poly_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 13,
  parameter int COEF_W = 13,
  parameter int SHIFT  = COEF_W - 1,
  localparam int AW     = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     sample_valid_i,
  input  logic                     phase_i,
  input  logic                     coef_we_i,
  input  logic [AW-1:0]            coef_addr_i,
  input  logic signed [COEF_W-1:0] coef_data_i,
  output logic signed [DATA_W-1:0] even_o,
  output logic                     even_valid_o,
  output logic signed [DATA_W-1:0] odd_o,
  output logic                     odd_valid_o
);
  phase_e ph;
  assign ph = phase_e'(phase_i);

  logic en_even, en_odd;
  assign en_even = sample_valid_i && (ph == PH_EVEN);
  assign en_odd  = sample_valid_i && (ph == PH_ODD);

  logic signed [COEF_W-1:0] coef_sel [TAPS];
  logic signed [PROD_W-1:0] prod     [TAPS];
  logic signed [ACC_W-1:0]  sum_even, sum_odd, sum_sel;
  logic signed [DATA_W-1:0] res;

  sym_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) i_coef (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (coef_we_i),
    .addr_i    (coef_addr_i),
    .data_i    (coef_data_i),
    .odd_sel_i (ph == PH_ODD),
    .coef_o    (coef_sel)
  );

  sym_shared_mult #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W)) i_mult (
    .sample_i (sample_i),
    .coef_i   (coef_sel),
    .prod_o   (prod)
  );

  // demux: each chain only advances on its own phase
  sym_tap_chain #(.TAPS(TAPS), .PROD_W(PROD_W), .ACC_W(ACC_W)) i_chain_even (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_even),
    .prod_i (prod),
    .sum_o  (sum_even)
  );

  sym_tap_chain #(.TAPS(TAPS), .PROD_W(PROD_W), .ACC_W(ACC_W)) i_chain_odd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_odd),
    .prod_i (prod),
    .sum_o  (sum_odd)
  );

  assign sum_sel = (ph == PH_ODD) ? sum_odd : sum_even;

  sym_round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .SHIFT(SHIFT)) i_rnd (
    .sum_i (sum_sel),
    .res_o (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_o       <= '0;
      odd_o        <= '0;
      even_valid_o <= 1'b0;
      odd_valid_o  <= 1'b0;
    end else begin
      even_valid_o <= en_even;
      odd_valid_o  <= en_odd;
      if (en_even) even_o <= res;
      if (en_odd)  odd_o  <= res;
    end
  end
endmodule

// File: rtl/sym_poly_subfilter_chk.sv
module sym_poly_subfilter_chk #(
  parameter int DATA_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic              phase_i,
  input logic [DATA_W-1:0] even_o,
  input logic              even_valid_o,
  input logic [DATA_W-1:0] odd_o,
  input logic              odd_valid_o
);
  a_r5_valid_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({even_valid_o, odd_valid_o}));

  a_r5_even_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !phase_i) |=> even_valid_o);

  a_r5_odd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && phase_i) |=> odd_valid_o);

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> ($stable(even_o) && $stable(odd_o) && !even_valid_o && !odd_valid_o));

  a_r4_even_untouched_by_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && phase_i) |=> $stable(even_o));

  a_r4_odd_untouched_by_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !phase_i) |=> $stable(odd_o));
endmodule

bind sym_poly_subfilter sym_poly_subfilter_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .phase_i        (phase_i),
  .even_o         (even_o),
  .even_valid_o   (even_valid_o),
  .odd_o          (odd_o),
  .odd_valid_o    (odd_valid_o)
);

// File: tb/test_sym_poly_subfilter.sv
module test_sym_poly_subfilter;
  localparam int TAPS = 4, DW = 13, CW = 13, SH = 12, AW = 2;

  logic clk = 0, rst_n = 0;
  logic signed [DW-1:0] smp = '0;
  logic vld = 0, ph = 0, cwe = 0;
  logic [AW-1:0] caddr = '0;
  logic signed [CW-1:0] cdata = '0;
  logic signed [DW-1:0] ev, od;
  logic ev_v, od_v;

  int errors = 0, checks = 0;
  longint cf [TAPS];
  longint he [TAPS];
  longint ho [TAPS];
  longint exp_e = 0, exp_o = 0;

  always #10 clk = ~clk;

  sym_poly_subfilter #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW)) i_sym_poly_subfilter (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .sample_valid_i(vld), .phase_i(ph),
    .coef_we_i(cwe), .coef_addr_i(caddr), .coef_data_i(cdata),
    .even_o(ev), .even_valid_o(ev_v), .odd_o(od), .odd_valid_o(od_v));

  function automatic longint rnd_sat(longint s);
    longint r = (s + (64'sd1 <<< (SH-1))) >>> SH;
    if (r > 4095) r = 4095;
    if (r < -4096) r = -4096;
    return r;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req, bit ve, bit vo);
    chk(req, "even_o", longint'(ev), exp_e);
    chk(req, "odd_o", longint'(od), exp_o);
    chk(req, "even_valid_o", longint'(ev_v), longint'(ve));
    chk(req, "odd_valid_o", longint'(od_v), longint'(vo));
  endtask

  // drive at negedge, accepted at next posedge, checked at the following negedge
  task automatic send(string req, longint x, bit p, bit do_chk = 1);
    longint s = 0;
    smp = DW'(x); ph = p; vld = 1;
    if (!p) begin
      for (int t = TAPS-1; t > 0; t--) he[t] = he[t-1];
      he[0] = x;
      for (int t = 0; t < TAPS; t++) s += cf[t] * he[t];
      exp_e = rnd_sat(s);
    end else begin
      for (int t = TAPS-1; t > 0; t--) ho[t] = ho[t-1];
      ho[0] = x;
      for (int t = 0; t < TAPS; t++) s += cf[TAPS-1-t] * ho[t];
      exp_o = rnd_sat(s);
    end
    @(negedge clk);
    vld = 0;
    if (do_chk) check_outs(req, !p, p);
  endtask

  task automatic load(longint c0, longint c1, longint c2, longint c3);
    longint v [TAPS] = '{c0, c1, c2, c3};
    for (int t = 0; t < TAPS; t++) begin
      cwe = 1; caddr = AW'(t); cdata = CW'(v[t]); cf[t] = v[t];
      @(negedge clk);
    end
    cwe = 0;
  endtask

  task automatic flush();
    for (int t = 0; t < TAPS; t++) begin
      send("R9", 0, 0, 0);
      send("R9", 0, 1, 0);
    end
  endtask

  task automatic t_reset();
    check_outs("R1", 0, 0);
    // zero coefficients after reset: even an impulse yields 0
    send("R1", 1234, 0);
    send("R1", -777, 1);
  endtask

  task automatic t_impulse();
    load(1000, -2000, 3000, 500);
    flush();
    send("R2", 2048, 0);
    for (int i = 0; i < TAPS; i++) send("R2", 0, 0);
    send("R3", 2048, 1);
    for (int i = 0; i < TAPS; i++) send("R3", 0, 1);
  endtask

  task automatic t_interleave();
    int seed = 7;
    load(-1500, 2222, 901, -3333);
    flush();
    for (int i = 0; i < 40; i++) begin
      longint x;
      seed = seed * 1103515245 + 12345;
      x = longint'((seed >>> 8) % 4096);
      send((i % 3 == 2) ? "R4" : ((i % 2) ? "R3" : "R2"), x, bit'((i % 3) == 2 ? 1 : i % 2));
    end
  endtask

  task automatic t_idle();
    send("R6", 1500, 0);
    send("R6", -900, 1);
    for (int i = 0; i < 5; i++) begin
      smp = DW'(i * 313); ph = bit'(i % 2);
      @(negedge clk);
      check_outs("R6", 0, 0);
    end
    // history untouched: next results still follow model
    send("R6", 100, 0);
    send("R6", 200, 1);
  endtask

  task automatic t_round();
    load(1, 0, 0, 0);
    flush();
    send("R7", 2048, 0);
    send("R7", 2047, 0);
    send("R7", -2048, 0);
    send("R7", -2049, 0);
    send("R7", 2048, 1);
  endtask

  task automatic t_sat();
    load(4095, 4095, 4095, 4095);
    flush();
    for (int i = 0; i < TAPS; i++) send("R8", 4095, 0);
    for (int i = 0; i < TAPS; i++) send("R8", -4096, 1);
    load(-4096, -4096, -4096, -4096);
    flush();
    for (int i = 0; i < TAPS; i++) send("R8", -4096, 0);
    chk("R8", "even max", longint'(ev), 4095);
  endtask

  task automatic t_coef_order();
    load(0, 0, 0, 4000);
    flush();
    send("R9", 2048, 0);
    chk("R9", "c0 applied to newest even", longint'(ev), 0);
    send("R9", 2048, 1);
    chk("R9", "c3 applied to newest odd", longint'(od), 2000);
  endtask

  initial begin
    for (int t = 0; t < TAPS; t++) begin cf[t] = 0; he[t] = 0; ho[t] = 0; end
    repeat (3) @(negedge clk);
    check_outs("R1", 0, 0);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_impulse();
    t_interleave();
    t_idle();
    t_round();
    t_sat();
    t_coef_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule